// File: doc/BRIEF.md
# Reversible Six-State Odd/Even Sequence Counter

This block is a 3-bit synchronous counter. Its state bits are A (least significant), B and C (most significant), and each bit is held in a JK-style flip-flop. The counter does not count in binary. It walks a fixed loop of six values.

- Forward direction: 1, 3, 5, 7, 4, 2, then back to 1.
- Reverse direction: the same loop backwards, 2, 4, 7, 5, 3, 1, then back to 2.

One direction input picks the loop direction on every clock. A count enable gates all updates. The J and K inputs of every flip-flop are brought out so that the excitation can be observed.

All three flip-flops share one clock edge. Each J and K is a multiplexer between a forward expression and a reverse expression, with the direction input as the select. The values 0 and 6 are outside the loop. The merged equations move the counter from either value onto the loop in a single enabled clock, so no extra recovery logic is needed. A synchronous reset loads a parameter value, which is 1 by default.

Top module: `rev_seq_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state_o` takes the value `RST_STATE` (default 3'd1) after that edge, whatever the values of `en_i` and `up_i`.
- R2: With `en_i` = 1 and `up_i` = 1, each edge moves `state_o` one step along the forward loop: 1→3, 3→5, 5→7, 7→4, 4→2, 2→1.
- R3: With `en_i` = 1 and `up_i` = 0, each edge moves `state_o` one step along the reverse loop: 2→4, 4→7, 7→5, 5→3, 3→1, 1→2.
- R4: With `en_i` = 0 and no reset, `state_o` keeps its value across the edge.
- R5: When `up_i` changes between two enabled edges, the next edge moves to the neighbour of the current state in the newly selected direction. The loop does not restart.
- R6: From 0 or 6, one enabled edge leads to 1 when `up_i` = 1 and to 2 when `up_i` = 0.
- R7: Bit i of `j_o` and of `k_o` (bit 0 = A, bit 2 = C) follow the JK excitation rule for the transition of `state_o` bit i that the next enabled edge makes. For a bit that goes 0→0, J is 0. For 0→1, J is 1. For 1→0, K is 1. For 1→1, K is 0. The flip-flops obey J=K=1 toggle, J=1/K=0 set, J=0/K=1 clear and J=K=0 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state bits update on its rising edge |
| rst | input | 1 | Synchronous reset, active high, loads `RST_STATE` |
| up_i | input | 1 | Direction select: 1 = forward loop, 0 = reverse loop |
| en_i | input | 1 | Count enable; 0 holds the state |
| state_o | output | 3 | Current state, {C,B,A} |
| j_o | output | 3 | J input of each flip-flop, {C,B,A} |
| k_o | output | 3 | K input of each flip-flop, {C,B,A} |

## Verification
The state result of an edge is due on `state_o` right after that edge, because exactly one register stage lies between the inputs and the state. `j_o` and `k_o` are combinational in the present state and `up_i`, so they are due in the same cycle as the inputs that produce them.

The bench changes its inputs on the falling edge. It checks `j_o`/`k_o` just after that change and checks `state_o` just after the following rising edge, against a successor table of its own.

Three instances with reset values 1, 0 and 6 run side by side. This is how the unused states are reached without a load port.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned STATE_W = 3;
  localparam int unsigned IDX_A   = 0;
  localparam int unsigned IDX_B   = 1;
  localparam int unsigned IDX_C   = 2;

  typedef logic [STATE_W-1:0] state_t;

  // Loop successor, written as a table; used only by the checks.
  function automatic state_t loop_next(input state_t s, input logic fwd);
    state_t n;
    if (fwd) begin
      case (s)
        3'd1: n = 3'd3;
        3'd3: n = 3'd5;
        3'd5: n = 3'd7;
        3'd7: n = 3'd4;
        3'd4: n = 3'd2;
        default: n = 3'd1;
      endcase
    end else begin
      case (s)
        3'd2: n = 3'd4;
        3'd4: n = 3'd7;
        3'd7: n = 3'd5;
        3'd5: n = 3'd3;
        3'd3: n = 3'd1;
        default: n = 3'd2;
      endcase
    end
    return n;
  endfunction
endpackage

// File: rtl/rsc_excite.sv
module rsc_excite
  import rsc_pkg::*;
(
  input  state_t q,
  input  logic   up,
  output state_t j,
  output state_t k
);
  logic   a, b, c;
  state_t j_fwd, k_fwd, j_rev, k_rev;

  assign a = q[IDX_A];
  assign b = q[IDX_B];
  assign c = q[IDX_C];

  // Forward loop excitation.
  always_comb begin
    j_fwd[IDX_A] = ~c | b;
    k_fwd[IDX_A] = b & c;
    j_fwd[IDX_B] = a | c;
    k_fwd[IDX_B] = 1'b1;
    j_fwd[IDX_C] = a & b;
    k_fwd[IDX_C] = ~a;
  end

  // Reverse loop excitation.
  always_comb begin
    j_rev[IDX_A] = ~b & c;
    k_rev[IDX_A] = ~b & ~c;
    j_rev[IDX_B] = 1'b1;
    k_rev[IDX_B] = a | ~c;
    j_rev[IDX_C] = ~a & b;
    k_rev[IDX_C] = (~a & b) | (a & ~b);
  end

  for (genvar g = 0; g < STATE_W; g++) begin : g_sel
    assign j[g] = up ? j_fwd[g] : j_rev[g];
    assign k[g] = up ? k_fwd[g] : k_rev[g];
  end
endmodule

// File: rtl/rsc_jk_cell.sv
module rsc_jk_cell #(
  parameter logic RST_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_BIT;
    end else if (en) begin
      case ({j, k})
        2'b01:   q <= 1'b0;
        2'b10:   q <= 1'b1;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end

  p_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    (en && j && k) |=> (q != $past(q)));
  p_set_r7: assert property (@(posedge clk) disable iff (rst)
    (en && j && !k) |=> q);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !j && k) |=> !q);
endmodule

// File: rtl/rev_seq_counter.sv
module rev_seq_counter
  import rsc_pkg::*;
#(
  parameter logic [2:0] RST_STATE = 3'd1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       up_i,
  input  logic       en_i,
  output logic [2:0] state_o,
  output logic [2:0] j_o,
  output logic [2:0] k_o
);
  state_t q, j_w, k_w;

  rsc_excite u_excite (
    .q  (q),
    .up (up_i),
    .j  (j_w),
    .k  (k_w)
  );

  for (genvar i = 0; i < STATE_W; i++) begin : g_bit
    rsc_jk_cell #(.RST_BIT(RST_STATE[i])) u_cell (
      .clk (clk),
      .rst (rst),
      .en  (en_i),
      .j   (j_w[i]),
      .k   (k_w[i]),
      .q   (q[i])
    );
  end

  assign state_o = q;
  assign j_o     = j_w;
  assign k_o     = k_w;

  p_reset_r1: assert property (@(posedge clk) rst |=> (state_o == RST_STATE));
  p_fwd_step_r2: assert property (@(posedge clk) disable iff (rst)
    (en_i && up_i) |=> (state_o == loop_next($past(state_o), 1'b1)));
  p_rev_step_r3: assert property (@(posedge clk) disable iff (rst)
    (en_i && !up_i) |=> (state_o == loop_next($past(state_o), 1'b0)));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(state_o));
  p_turn_r5: assert property (@(posedge clk) disable iff (rst)
    (en_i && (up_i != $past(up_i))) |=> (state_o == loop_next($past(state_o), $past(up_i))));
  p_recover_r6: assert property (@(posedge clk) disable iff (rst)
    (en_i && (state_o == 3'd0 || state_o == 3'd6)) |=> (state_o == ($past(up_i) ? 3'd1 : 3'd2)));
endmodule

// File: tb/rev_seq_counter_tb.sv
module rev_seq_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDUT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic up  = 1'b1;
  logic [2:0] st [NDUT];
  logic [2:0] jj [NDUT];
  logic [2:0] kk [NDUT];
  logic [2:0] exp_st [NDUT];
  logic [2:0] rst_val [NDUT];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic prev_up = 1'b1;
  logic prev_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rev_seq_counter u_dut (.clk(clk), .rst(rst), .up_i(up), .en_i(en),
    .state_o(st[0]), .j_o(jj[0]), .k_o(kk[0]));
  rev_seq_counter #(.RST_STATE(3'd0)) u_dut_s0 (.clk(clk), .rst(rst), .up_i(up), .en_i(en),
    .state_o(st[1]), .j_o(jj[1]), .k_o(kk[1]));
  rev_seq_counter #(.RST_STATE(3'd6)) u_dut_s6 (.clk(clk), .rst(rst), .up_i(up), .en_i(en),
    .state_o(st[2]), .j_o(jj[2]), .k_o(kk[2]));

  function automatic logic [2:0] succ(input logic [2:0] s, input logic fwd);
    logic [2:0] n;
    if (fwd) begin
      case (s)
        3'd1: n = 3'd3; 3'd3: n = 3'd5; 3'd5: n = 3'd7;
        3'd7: n = 3'd4; 3'd4: n = 3'd2; 3'd2: n = 3'd1;
        default: n = 3'd1;
      endcase
    end else begin
      case (s)
        3'd2: n = 3'd4; 3'd4: n = 3'd7; 3'd7: n = 3'd5;
        3'd5: n = 3'd3; 3'd3: n = 3'd1; 3'd1: n = 3'd2;
        default: n = 3'd2;
      endcase
    end
    return n;
  endfunction

  // R7: excitation rule per bit for a transition cur -> nxt.
  function automatic bit jk_ok(input logic [2:0] cur, input logic [2:0] nxt,
                               input logic [2:0] j, input logic [2:0] k);
    bit ok = 1'b1;
    for (int b = 0; b < 3; b++) begin
      case ({cur[b], nxt[b]})
        2'b00: if (j[b] !== 1'b0) ok = 1'b0;
        2'b01: if (j[b] !== 1'b1) ok = 1'b0;
        2'b10: if (k[b] !== 1'b1) ok = 1'b0;
        default: if (k[b] !== 1'b0) ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

  task automatic check_state(input int d, input string tag);
    checks++;
    if (st[d] !== exp_st[d]) begin
      errors++;
      $display("FAIL %s dut%0d state actual=%0d expected=%0d", tag, d, st[d], exp_st[d]);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic d);
    string tag [NDUT];
    @(negedge clk);
    rst = r; en = e; up = d;
    #1;
    for (int i = 0; i < NDUT; i++) begin
      if (!r && e) begin
        checks++;
        if (!jk_ok(exp_st[i], succ(exp_st[i], d), jj[i], kk[i])) begin
          errors++;
          $display("FAIL R7 dut%0d state=%0d j actual=%b k actual=%b expected transition to %0d",
                   i, exp_st[i], jj[i], kk[i], succ(exp_st[i], d));
        end
      end
      if (r) tag[i] = "R1";
      else if (!e) tag[i] = "R4";
      else if (exp_st[i] == 3'd0 || exp_st[i] == 3'd6) tag[i] = "R6";
      else if (prev_en && d != prev_up) tag[i] = "R5";
      else if (d) tag[i] = "R2";
      else tag[i] = "R3";
      if (r) exp_st[i] = rst_val[i];
      else if (e) exp_st[i] = succ(exp_st[i], d);
    end
    if (!r && e) begin prev_up = d; prev_en = 1'b1; end
    if (r) prev_en = 1'b0;
    @(posedge clk);
    #1;
    for (int i = 0; i < NDUT; i++) check_state(i, tag[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_val[0] = 3'd1; rst_val[1] = 3'd0; rst_val[2] = 3'd6;
    for (int i = 0; i < NDUT; i++) exp_st[i] = rst_val[i];
    void'($urandom(32'd5150));
    // R1: reset state
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    // R6: recovery forward, then reverse
    step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    // R2: three forward loops; R3: three reverse loops
    for (int n = 0; n < 18; n++) step(1'b0, 1'b1, 1'b1);
    for (int n = 0; n < 18; n++) step(1'b0, 1'b1, 1'b0);
    // R5: turn around at every state (fwd, fwd, rev)
    for (int n = 0; n < 24; n++) step(1'b0, 1'b1, (n % 3) != 2);
    for (int n = 0; n < 24; n++) step(1'b0, 1'b1, (n % 3) == 2);
    // R4: hold with enable low in both directions
    for (int n = 0; n < 4; n++) step(1'b0, 1'b0, n[0]);
    // R1: reset mid-run
    step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    // Random mix
    for (int n = 0; n < 3000; n++)
      step(($urandom % 40) == 0, ($urandom % 4) != 0, $urandom % 2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule